// File: doc/BRIEF.md
# Enhanced Clock Victim Selector

This block picks which page frame to give up when memory runs short. It keeps two bits for each frame. A reference bit is set on any access to the frame. A modify bit is set on a write access. A hand register points at the next candidate. The frames form a ring.

When a caller asks for an eviction, the engine walks the ring from the hand, looking at one frame per clock. It returns the chosen frame index with a one-cycle done strobe, together with a flag that says whether the frame holds modified data. When that flag is set, the caller must save the frame before reusing it.

A mode input selects one of two policies, and its value is captured when the request is accepted:
- **Plain mode:** a frame that was referenced gets a second chance. Its reference bit is cleared and the walk moves on.
- **Enhanced mode:** frames are ranked by their (reference, modify) pair, and the walk leaves all bits untouched.

Moving pages, storage traffic and table updates belong to the surrounding system.

Top module: `clock_victim_sel`

## Requirements
- R1: After reset every reference and modify bit is 0, the hand is 0, and both `busy` and `evict_done` are low.
- R2: An access sets the reference bit of frame `acc_idx` on the next clock edge. If `acc_write` is 1, the access also sets that frame's modify bit; a read leaves the modify bit unchanged. An access takes priority over any clearing of the same frame on the same edge.
- R3: In plain mode the walk starts at the hand. Each clock it examines one frame. A frame whose reference bit is 1 has the bit cleared and is passed over. The first frame whose reference bit is 0 is the victim. With s frames passed over, `evict_done` rises s+1 edges after the edge that accepted the request.
- R4: In plain mode, when every reference bit is 1, the walk clears all of them in one full lap. It then picks the frame at the hand, with `evict_done` rising NFRAMES+1 edges after acceptance.
- R5: In enhanced mode the class of a frame is 2*reference+modify, and a lower class is preferred. If a class-0 frame exists, the victim is the first one met going from the hand in ring order. `evict_done` rises d+1 edges after acceptance, where d is its distance from the hand. No frame's bits are changed by the walk.
- R6: In enhanced mode with no class-0 frame, the victim is the first frame in ring order from the hand among those of the lowest class present. `evict_done` rises NFRAMES edges after acceptance.
- R7: `victim_dirty` equals the victim's modify bit as it stood just before selection.
- R8: On selection, the victim's reference and modify bits are cleared and the hand moves to the frame after the victim, wrapping from NFRAMES-1 to 0. The hand changes at no other time.
- R9: `busy` is high from the edge that accepts a request until the edge that raises `evict_done`. `evict_done` is a single-cycle pulse, with `victim_idx` and `victim_dirty` valid while it is high. A request made while busy is ignored.
- R10: The policy used is the value of `mode_enh` (1 = enhanced, 0 = plain) on the edge that accepts the request; later changes of `mode_enh` do not affect a walk already running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A frame access happens this cycle |
| acc_idx | input | IW | Index of the accessed frame |
| acc_write | input | 1 | The access is a write |
| mode_enh | input | 1 | 1 = enhanced class-ranked policy, 0 = plain second-chance |
| evict_req | input | 1 | Request a victim (accepted only when not busy) |
| busy | output | 1 | A walk is in progress |
| evict_done | output | 1 | One-cycle strobe: victim chosen |
| victim_idx | output | IW | Chosen frame, valid with `evict_done` |
| victim_dirty | output | 1 | Chosen frame was modified, valid with `evict_done` |
| hand | output | IW | Current ring position |
| ref_bits | output | NFRAMES | Reference bit of each frame |
| mod_bits | output | NFRAMES | Modify bit of each frame |

## Verification
The assertions check the following on every cycle:
- Accesses set their bits on the next edge.
- The done strobe lasts one cycle, and never overlaps `busy`.
- The dirty flag matches the victim's prior modify bit.
- The victim's bits are cleared.
- The hand lands just past the victim and moves at no other time.

Some properties depend on the whole history of the bits, and only the bench's scenarios can show them:
- that the victim is the right frame,
- the exact walk length in each mode,
- that a plain-mode walk clears the bits it passes over,
- that a request or mode change during a walk has no effect.

Those scenarios include a pseudo-random mix of accesses and evictions in both modes, a full plain lap, and an enhanced walk where every frame is dirty.

// File: rtl/clock_victim_sel.sv
module clock_victim_sel #(
  parameter int NFRAMES = 8,
  localparam int IW = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic [IW-1:0]      acc_idx,
  input  logic               acc_write,
  input  logic               mode_enh,
  input  logic               evict_req,
  output logic               busy,
  output logic               evict_done,
  output logic [IW-1:0]      victim_idx,
  output logic               victim_dirty,
  output logic [IW-1:0]      hand,
  output logic [NFRAMES-1:0] ref_bits,
  output logic [NFRAMES-1:0] mod_bits
);
  localparam logic [IW-1:0] LAST = IW'(NFRAMES - 1);

  logic [NFRAMES-1:0] ref_q, mod_q;
  logic [IW-1:0] hand_q, pos_q, cnt_q, best_q, vic_q;
  logic [2:0] bestc_q;
  logic scan_q, enh_q, done_q, dirty_q;

  logic [1:0] cls;
  logic [IW-1:0] pos_nx, pick_idx, pick_nx;
  logic hit00, pick, skip_clr;

  assign cls      = {ref_q[pos_q], mod_q[pos_q]};
  assign hit00    = (cls == 2'b00);
  assign pos_nx   = (pos_q == LAST) ? '0 : pos_q + 1'b1;
  assign skip_clr = scan_q && !enh_q && ref_q[pos_q];

  always_comb begin
    pick = 1'b0;
    pick_idx = pos_q;
    if (scan_q) begin
      if (!enh_q) begin
        pick = !ref_q[pos_q];
      end else begin
        pick = hit00 || (cnt_q == LAST);
        if (!hit00 && ({1'b0, cls} >= bestc_q)) pick_idx = best_q;
      end
    end
  end

  assign pick_nx = (pick_idx == LAST) ? '0 : pick_idx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q   <= '0;
      mod_q   <= '0;
      hand_q  <= '0;
      pos_q   <= '0;
      cnt_q   <= '0;
      best_q  <= '0;
      bestc_q <= 3'd4;
      vic_q   <= '0;
      scan_q  <= 1'b0;
      enh_q   <= 1'b0;
      done_q  <= 1'b0;
      dirty_q <= 1'b0;
    end else begin
      done_q <= pick;
      if (pick) begin
        vic_q   <= pick_idx;
        dirty_q <= mod_q[pick_idx];
      end

      if (!scan_q) begin
        if (evict_req) begin
          scan_q  <= 1'b1;
          enh_q   <= mode_enh;
          pos_q   <= hand_q;
          cnt_q   <= '0;
          bestc_q <= 3'd4;
        end
      end else if (pick) begin
        scan_q <= 1'b0;
        hand_q <= pick_nx;
      end else begin
        pos_q <= pos_nx;
        cnt_q <= cnt_q + 1'b1;
        if (enh_q && ({1'b0, cls} < bestc_q)) begin
          bestc_q <= {1'b0, cls};
          best_q  <= pos_q;
        end
      end

      for (int i = 0; i < NFRAMES; i++) begin
        if (acc_valid && acc_idx == IW'(i)) begin
          ref_q[i] <= 1'b1;
          if (acc_write) mod_q[i] <= 1'b1;
        end else begin
          if ((pick && pick_idx == IW'(i)) || (skip_clr && pos_q == IW'(i)))
            ref_q[i] <= 1'b0;
          if (pick && pick_idx == IW'(i))
            mod_q[i] <= 1'b0;
        end
      end
    end
  end

  assign busy         = scan_q;
  assign evict_done   = done_q;
  assign victim_idx   = vic_q;
  assign victim_dirty = dirty_q;
  assign hand         = hand_q;
  assign ref_bits     = ref_q;
  assign mod_bits     = mod_q;
endmodule

// File: rtl/clock_victim_sel_chk.sv
module clock_victim_sel_chk #(
  parameter int NFRAMES = 8,
  localparam int IW = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               acc_valid,
  input logic [IW-1:0]      acc_idx,
  input logic               acc_write,
  input logic               busy,
  input logic               evict_done,
  input logic [IW-1:0]      victim_idx,
  input logic               victim_dirty,
  input logic [IW-1:0]      hand,
  input logic [NFRAMES-1:0] ref_bits,
  input logic [NFRAMES-1:0] mod_bits
);
  logic [NFRAMES-1:0] mod_d;
  logic [IW-1:0] hand_exp;

  always_ff @(posedge clk) begin
    if (!rst_n) mod_d <= '0;
    else        mod_d <= mod_bits;
  end

  assign hand_exp = (victim_idx == IW'(NFRAMES - 1)) ? '0 : victim_idx + 1'b1;

  // R2
  ref_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> ref_bits[$past(acc_idx)]);

  // R2
  mod_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write) |=> mod_bits[$past(acc_idx)]);

  // R7
  dirty_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evict_done |-> (victim_dirty == mod_d[victim_idx]));

  // R8
  victim_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_done && !$past(acc_valid)) |-> (!ref_bits[victim_idx] && !mod_bits[victim_idx]));

  // R8
  hand_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evict_done |-> (hand == hand_exp));

  // R8
  hand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !evict_done |-> $stable(hand));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evict_done |=> !evict_done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evict_done |-> !busy);
endmodule

bind clock_victim_sel clock_victim_sel_chk #(.NFRAMES(NFRAMES)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_idx(acc_idx),
  .acc_write(acc_write), .busy(busy), .evict_done(evict_done),
  .victim_idx(victim_idx), .victim_dirty(victim_dirty), .hand(hand),
  .ref_bits(ref_bits), .mod_bits(mod_bits)
);

// File: tb/clock_victim_sel_test.sv
`timescale 1ns/1ps
module clock_victim_sel_test;
  localparam int NF = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic [IW-1:0] acc_idx = '0;
  logic acc_write = 1'b0;
  logic mode_enh = 1'b0;
  logic evict_req = 1'b0;
  logic busy, evict_done, victim_dirty;
  logic [IW-1:0] victim_idx, hand;
  logic [NF-1:0] ref_bits, mod_bits;

  int checks = 0;
  int fails = 0;
  bit mref[NF];
  bit mmod[NF];
  int mhand;
  logic [15:0] lf = 16'hACE1;

  always #4 clk = ~clk;

  clock_victim_sel #(.NFRAMES(NF)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_idx(acc_idx),
    .acc_write(acc_write), .mode_enh(mode_enh), .evict_req(evict_req),
    .busy(busy), .evict_done(evict_done), .victim_idx(victim_idx),
    .victim_dirty(victim_dirty), .hand(hand), .ref_bits(ref_bits),
    .mod_bits(mod_bits)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int vec_ref();
    int v = 0;
    for (int i = 0; i < NF; i++) if (mref[i]) v |= (1 << i);
    return v;
  endfunction

  function automatic int vec_mod();
    int v = 0;
    for (int i = 0; i < NF; i++) if (mmod[i]) v |= (1 << i);
    return v;
  endfunction

  task automatic rnd();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NF; i++) begin mref[i] = 0; mmod[i] = 0; end
    mhand = 0;
  endtask

  task automatic do_access(input int idx, input bit wr);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_idx = IW'(idx);
    acc_write = wr;
    @(negedge clk);
    acc_valid = 1'b0;
    acc_write = 1'b0;
    mref[idx] = 1;
    if (wr) mmod[idx] = 1;
    chk(ref_bits[idx] == 1'b1, "R2", int'(ref_bits[idx]), 1);
    chk(int'(mod_bits) == vec_mod(), "R2", int'(mod_bits), vec_mod());
    chk(int'(ref_bits) == vec_ref(), "R2", int'(ref_bits), vec_ref());
  endtask

  task automatic do_evict(input bit enh, input bit poke);
    int ev, ed, el, lat, p, best, bi;
    bit found, full;
    string tag;
    found = 0; full = 0; ev = 0; el = 0; bi = 0; best = 4;
    if (!enh) begin
      p = mhand;
      el = 1;
      while (mref[p]) begin
        mref[p] = 0;
        p = (p + 1) % NF;
        el++;
      end
      full = (el == NF + 1);
      ev = p;
      tag = full ? "R4" : "R3";
    end else begin
      for (int k = 0; k < NF; k++) begin
        p = (mhand + k) % NF;
        if (!found) begin
          if (!mref[p] && !mmod[p]) begin
            found = 1; ev = p; el = k + 1;
          end else if (2 * mref[p] + mmod[p] < best) begin
            best = 2 * mref[p] + mmod[p]; bi = p;
          end
        end
      end
      if (!found) begin ev = bi; el = NF; end
      tag = found ? "R5" : "R6";
    end
    ed = mmod[ev];
    mref[ev] = 0;
    mmod[ev] = 0;
    mhand = (ev + 1) % NF;

    @(negedge clk);
    mode_enh = enh;
    evict_req = 1'b1;
    @(negedge clk);
    evict_req = 1'b0;
    lat = 0;
    chk(busy == 1'b1, "R9", int'(busy), 1);
    while (!evict_done && lat < 4 * NF) begin
      @(negedge clk);
      lat++;
      if (poke && lat == 1 && el >= 3) begin
        evict_req = 1'b1;
        mode_enh = !enh;
      end else begin
        evict_req = 1'b0;
      end
    end
    evict_req = 1'b0;
    chk(lat == el, tag, lat, el);
    chk(int'(victim_idx) == ev, poke ? "R10" : tag, int'(victim_idx), ev);
    chk(victim_dirty == ed[0], "R7", int'(victim_dirty), ed);
    chk(int'(hand) == mhand, "R8", int'(hand), mhand);
    chk(int'(ref_bits) == vec_ref(), "R8", int'(ref_bits), vec_ref());
    chk(int'(mod_bits) == vec_mod(), "R8", int'(mod_bits), vec_mod());
    @(negedge clk);
    chk(!evict_done && !busy, "R9", int'({evict_done, busy}), 0);
    mode_enh = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1
    chk(ref_bits == '0 && mod_bits == '0, "R1", int'({ref_bits, mod_bits}), 0);
    chk(hand == '0, "R1", int'(hand), 0);
    chk(!busy && !evict_done, "R1", int'({busy, evict_done}), 0);

    // R4: full plain lap
    for (int i = 0; i < NF; i++) do_access(i, 1'b0);
    do_evict(1'b0, 1'b0);

    // R6 and R7: every frame dirty and referenced
    do_reset();
    for (int i = 0; i < NF; i++) do_access(i, 1'b1);
    do_evict(1'b1, 1'b1);
    do_evict(1'b1, 1'b0);

    // R3 and R5: frames skipped or chosen per pattern, mode changed mid-walk (R10)
    do_reset();
    do_access(0, 1'b0);
    do_access(1, 1'b1);
    do_access(3, 1'b0);
    do_evict(1'b0, 1'b1);
    do_evict(1'b1, 1'b1);

    // pseudo-random mix over all four classes and hand positions
    for (int n = 0; n < 600; n++) begin
      rnd();
      if (lf[3:0] < 4'd11) begin
        do_access(int'(lf[6:4]), lf[7]);
      end else begin
        do_evict(lf[8], lf[9]);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule